// File: doc/BRIEF.md
# Serial Configuration Bitstream Loader

The loader takes one configuration bit per rising edge of the configuration clock and walks it through a fixed grammar. First comes a synchronisation header: a run of ones, a four-bit sync word, a 24-bit length count and a four-bit all-ones trailer. After it, the stream is a sequence of data frames. Each frame has one low start bit, `FRAME_BITS` payload bits and three high stop bits. Each good frame is handed out on a parallel bus with its index and a one-cycle strobe.

A down-counter is loaded with the length count at the end of the header and steps once per configuration clock. The cycle after it reaches zero, a sticky completion flag rises. When `NUM_FRAMES` frames have been taken locally, the loader stops capturing. From then on every incoming bit is repeated on a daisy-chain output half a clock later, on the falling edge, for the next device in the chain. A malformed trailer, start bit or stop bit sets a sticky error that freezes frame output until reset.

Top module: `cfgld_loader`

## Requirements
- R1: The header search accepts the sync word 0,0,1,0 (first bit received first) only after at least 8 consecutive 1 bits. Extra leading 1s are accepted. A 0 after fewer than 8 ones restarts the count. A sync-word mismatch returns to the search, with a mismatching 1 counted as the first one of a new run.
- R2: The 24 bits after the sync word form the length count L, most significant bit first. The 4 bits that follow are the trailer. The bit after the last trailer bit is the first start bit.
- R3: With L ≥ 1 and counting the edge that samples the last trailer bit as 0, `done` is high after rising edge L+1 and stays high until reset. This holds regardless of frame progress.
- R4: A frame is a 0 start bit, then `FRAME_BITS` payload bits with the first received landing in the MSB of `frame_data`, then three 1 stop bits. After the edge that samples the third stop bit, `frame_valid` is high for exactly one cycle with the payload on `frame_data`.
- R5: `frame_idx` counts the frames of a stream from 0 up to `NUM_FRAMES`-1 and is stable with each strobe.
- R6: A start bit of 1 or any stop bit of 0 sets `frame_err` after that edge. The flag holds until reset, and no `frame_valid` follows.
- R7: Any 0 among the four trailer bits sets `frame_err` after that edge, and no frame is delivered.
- R8: After `NUM_FRAMES` good frames, later bits raise no `frame_valid`. Each one sampled on a rising edge appears on `daisy_out` from the following falling edge. At all other times `daisy_out` is 1.
- R9: A synchronous active-high `rst` returns the loader to the header search and clears `done`, `frame_err`, `frame_valid` and `frame_idx`, and sets `daisy_out` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial configuration data, sampled on the rising edge |
| frame_data | output | FRAME_BITS | Payload of the last good frame |
| frame_idx | output | cw(NUM_FRAMES) | Index of the last good frame |
| frame_valid | output | 1 | One-cycle strobe for a good frame |
| frame_err | output | 1 | Sticky framing or trailer error |
| done | output | 1 | Sticky length-count completion |
| daisy_out | output | 1 | Pass-through data, updated on the falling edge |

## Verification
A clean stream is given all-zero, all-one and mixed payloads followed by a pass-through pattern with zeros in it. This separates MSB ordering, index stepping and falling-edge forwarding from a stuck or idle-high output. A second stream is preceded by a too-short run of ones and a corrupted sync word, and uses a length count that expires mid-frame. That stream shows that the header search recovers and that completion is tied to the count alone. Separate streams corrupt a start bit, a stop bit and a trailer bit, telling a sticky error apart from a single-frame drop. A reset issued after completion shows every flag and the index returning to their idle values.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int PRE_ONES  = 8;
    localparam int SYNC_BITS = 4;
    localparam logic [SYNC_BITS-1:0] SYNC_PAT = 4'b0010;
    localparam int LEN_BITS  = 24;
    localparam int TRL_BITS  = 4;
    localparam int STOP_BITS = 3;

    typedef enum logic [2:0] {H_PRE, H_SYNC, H_LEN, H_TRL, H_FIN} hdr_st_e;
    typedef enum logic [2:0] {F_START, F_DATA, F_STOP, F_PASS, F_ERR} frm_st_e;

    // header events handed to the counter and frame stages
    typedef struct packed {
        logic load;   // last trailer bit on din this cycle
        logic bad;    // trailer bit on din is 0
        logic fin;    // header fully consumed
    } hdr_ev_t;

    function automatic int cw(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfgld_hdr.sv
module cfgld_hdr
    import cfgld_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                din,
    output hdr_ev_t             ev,
    output logic [LEN_BITS-1:0] len
);
    localparam int OW = cw(PRE_ONES + 1);
    localparam int PW = cw(imax(LEN_BITS, imax(SYNC_BITS, TRL_BITS)));

    hdr_st_e       st;
    logic [OW-1:0] ones;
    logic [PW-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= H_PRE;
            ones <= '0;
            pos  <= '0;
            len  <= '0;
        end else begin
            case (st)
                H_PRE: begin
                    if (din) begin
                        if (ones != OW'(PRE_ONES)) ones <= ones + 1'b1;
                    end else if (ones == OW'(PRE_ONES)) begin
                        st  <= H_SYNC;
                        pos <= PW'(1);
                    end else begin
                        ones <= '0;
                    end
                end
                H_SYNC: begin
                    if (din == SYNC_PAT[PW'(SYNC_BITS-1) - pos]) begin
                        if (pos == PW'(SYNC_BITS-1)) begin
                            st  <= H_LEN;
                            pos <= '0;
                        end else begin
                            pos <= pos + 1'b1;
                        end
                    end else begin
                        st   <= H_PRE;
                        ones <= din ? OW'(1) : '0;
                    end
                end
                H_LEN: begin
                    len <= {len[LEN_BITS-2:0], din};
                    if (pos == PW'(LEN_BITS-1)) begin
                        st  <= H_TRL;
                        pos <= '0;
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
                H_TRL: begin
                    if (pos == PW'(TRL_BITS-1)) st <= H_FIN;
                    else                        pos <= pos + 1'b1;
                end
                default: st <= H_FIN;
            endcase
        end
    end

    always_comb begin
        ev.load = (st == H_TRL) && (pos == PW'(TRL_BITS-1));
        ev.bad  = (st == H_TRL) && !din;
        ev.fin  = (st == H_FIN);
    end

    // R2: once the header is consumed it stays consumed until reset
    p_fin_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        ev.fin |=> ev.fin);
    // R2: the load event precedes the finished state by exactly one edge
    p_load_then_fin_r2: assert property (@(posedge clk) disable iff (rst)
        ev.load |=> ev.fin);

endmodule

// File: rtl/cfgld_lenctr.sv
module cfgld_lenctr
    import cfgld_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                run,
    input  logic [LEN_BITS-1:0] len,
    output logic                done
);
    logic [LEN_BITS-1:0] cnt;
    logic                hit;   // counter reached zero

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            hit  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= hit;
            if (load) begin
                cnt <= len;
                if (len == '0) hit <= 1'b1;
            end else if (run && cnt != '0) begin
                cnt <= cnt - 1'b1;
                if (cnt == LEN_BITS'(1)) hit <= 1'b1;
            end
        end
    end

    // R3: completion is sticky
    p_done_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> done);
    // R3: completion is only reported with the counter drained
    p_done_zero_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt == '0));

endmodule

// File: rtl/cfgld_frm.sv
module cfgld_frm
    import cfgld_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    parameter int FRAME_BITS = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          din,
    input  logic                          active,
    input  logic                          hdr_bad,
    output logic [FRAME_BITS-1:0]         data,
    output logic [cw(NUM_FRAMES)-1:0]     idx,
    output logic                          valid,
    output logic                          err,
    output logic                          pass
);
    localparam int IW = cw(NUM_FRAMES);
    localparam int BW = cw(imax(FRAME_BITS, STOP_BITS));

    frm_st_e               st;
    logic [BW-1:0]         bcnt;
    logic [FRAME_BITS-1:0] shreg;
    logic [IW-1:0]         fcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= F_START;
            bcnt  <= '0;
            shreg <= '0;
            fcnt  <= '0;
            data  <= '0;
            idx   <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (hdr_bad) begin
                st <= F_ERR;
            end else begin
                case (st)
                    F_START: begin
                        if (active) begin
                            st   <= din ? F_ERR : F_DATA;
                            bcnt <= '0;
                        end
                    end
                    F_DATA: begin
                        shreg <= {shreg[FRAME_BITS-2:0], din};
                        if (bcnt == BW'(FRAME_BITS-1)) begin
                            st   <= F_STOP;
                            bcnt <= '0;
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    F_STOP: begin
                        if (!din) begin
                            st <= F_ERR;
                        end else if (bcnt == BW'(STOP_BITS-1)) begin
                            valid <= 1'b1;
                            data  <= shreg;
                            idx   <= fcnt;
                            if (fcnt == IW'(NUM_FRAMES-1)) begin
                                st <= F_PASS;
                            end else begin
                                fcnt <= fcnt + 1'b1;
                                st   <= F_START;
                            end
                        end else begin
                            bcnt <= bcnt + 1'b1;
                        end
                    end
                    F_PASS:  st <= F_PASS;
                    default: st <= F_ERR;
                endcase
            end
        end
    end

    assign err  = (st == F_ERR);
    assign pass = (st == F_PASS);

    // R4: a frame strobe lasts a single cycle
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    // R5: delivered index never exceeds the local frame count
    p_idx_range_r5: assert property (@(posedge clk) disable iff (rst)
        valid |-> (int'(idx) < NUM_FRAMES));
    // R6: error is sticky and blocks every later strobe
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        err |=> (err && !valid));
    // R8: nothing is captured while passing bits through
    p_pass_no_capture_r8: assert property (@(posedge clk) disable iff (rst)
        (pass && $past(pass)) |-> !valid);

endmodule

// File: rtl/cfgld_daisy.sv
module cfgld_daisy (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic fwd,
    output logic dout
);
    logic bit_q;
    logic fwd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= 1'b1;
            fwd_q <= 1'b0;
        end else begin
            bit_q <= din;
            fwd_q <= fwd;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) dout <= 1'b1;
        else     dout <= fwd_q ? bit_q : 1'b1;
    end

    // R8: idle level is high whenever nothing is being forwarded
    p_idle_high_r8: assert property (@(negedge clk) disable iff (rst)
        !$past(fwd_q) |-> dout);

endmodule

// File: rtl/cfgld_loader.sv
module cfgld_loader
    import cfgld_pkg::*;
#(
    parameter int NUM_FRAMES = 4,
    parameter int FRAME_BITS = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      din,
    output logic [FRAME_BITS-1:0]     frame_data,
    output logic [cw(NUM_FRAMES)-1:0] frame_idx,
    output logic                      frame_valid,
    output logic                      frame_err,
    output logic                      done,
    output logic                      daisy_out
);
    hdr_ev_t             ev;
    logic [LEN_BITS-1:0] len;
    logic                pass;

    cfgld_hdr u_hdr (
        .clk (clk),
        .rst (rst),
        .din (din),
        .ev  (ev),
        .len (len)
    );

    cfgld_lenctr u_ctr (
        .clk  (clk),
        .rst  (rst),
        .load (ev.load),
        .run  (ev.fin),
        .len  (len),
        .done (done)
    );

    cfgld_frm #(
        .NUM_FRAMES (NUM_FRAMES),
        .FRAME_BITS (FRAME_BITS)
    ) u_frm (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .active  (ev.fin),
        .hdr_bad (ev.bad),
        .data    (frame_data),
        .idx     (frame_idx),
        .valid   (frame_valid),
        .err     (frame_err),
        .pass    (pass)
    );

    cfgld_daisy u_dsy (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .fwd  (pass),
        .dout (daisy_out)
    );

    // R9: the cycle after reset every indicator is back at idle
    p_reset_clears_r9: assert property (@(posedge clk)
        $past(rst) |-> (!done && !frame_err && !frame_valid && frame_idx == '0));

endmodule

// File: tb/cfgld_loader_test.sv
module cfgld_loader_test;
    localparam int NF = 4;
    localparam int FB = 16;
    localparam int IW = (NF <= 1) ? 1 : $clog2(NF);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          din = 1'b1;
    logic [FB-1:0] frame_data;
    logic [IW-1:0] frame_idx;
    logic          frame_valid, frame_err, done, daisy_out;

    always #4 clk = ~clk;

    cfgld_loader #(.NUM_FRAMES(NF), .FRAME_BITS(FB)) uut (
        .clk(clk), .rst(rst), .din(din),
        .frame_data(frame_data), .frame_idx(frame_idx),
        .frame_valid(frame_valid), .frame_err(frame_err),
        .done(done), .daisy_out(daisy_out)
    );

    int n_cmp = 0, n_bad = 0;
    logic [FB-1:0] q_data[$];
    int            q_idx[$];
    bit  in_body, exp_err, exp_daisy, finished;
    int  edges_after, len_l, good_n;
    string frm_req = "R4", done_req = "R3", err_req = "R6", extra_req = "R8";

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard pop and per-cycle flag checks
    always @(posedge clk) begin
        #2;
        if (!rst && !finished) begin
            if (frame_valid) begin
                if (q_data.size() == 0) begin
                    chk(0, extra_req, 1, 0);
                end else begin
                    logic [FB-1:0] ed;
                    int ei;
                    ed = q_data.pop_front();
                    ei = q_idx.pop_front();
                    chk(frame_data == ed, frm_req, frame_data, ed);
                    chk(int'(frame_idx) == ei, "R5", frame_idx, ei);
                end
            end
            chk(frame_err == exp_err, err_req, frame_err, exp_err);
            chk(done == (in_body && edges_after >= len_l + 1), done_req, done,
                in_body && edges_after >= len_l + 1);
        end
    end

    task automatic send_bit(input bit b, input bit fwd);
        @(negedge clk);
        #1;
        chk(daisy_out == exp_daisy, "R8", daisy_out, exp_daisy);
        din = b;
        exp_daisy = fwd ? b : 1'b1;
        if (in_body) edges_after++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        din = 1'b1;
        chk(q_data.size() == 0, "R4", q_data.size(), 0);
        q_data.delete(); q_idx.delete();
        in_body = 0; exp_err = 0; exp_daisy = 1; edges_after = 0;
        len_l = 0; good_n = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        chk(done == 0, "R9", done, 0);
        chk(frame_err == 0, "R9", frame_err, 0);
        chk(frame_valid == 0, "R9", frame_valid, 0);
        chk(frame_idx == 0, "R9", frame_idx, 0);
        chk(daisy_out == 1, "R9", daisy_out, 1);
    endtask

    task automatic send_hdr(input int ones, input int len, input bit bad_trl);
        for (int i = 0; i < ones; i++) send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0);
        for (int i = 23; i >= 0; i--) send_bit(len[i], 1'b0);
        for (int i = 0; i < 4; i++) begin
            send_bit((bad_trl && i == 2) ? 1'b0 : 1'b1, 1'b0);
            if (bad_trl && i == 2) exp_err = 1;
        end
        len_l = len;
        in_body = 1;
    endtask

    task automatic send_frame(input logic [FB-1:0] d, input bit bad_start, input bit bad_stop);
        bit was_err;
        was_err = exp_err;
        send_bit(bad_start, 1'b0);
        if (bad_start) exp_err = 1;
        for (int i = FB - 1; i >= 0; i--) send_bit(d[i], 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(!bad_stop, 1'b0);
        if (bad_stop && !exp_err) exp_err = 1;
        send_bit(1'b1, 1'b0);
        if (!was_err && !exp_err) begin
            q_data.push_back(d);
            q_idx.push_back(good_n);
            good_n++;
        end
    endtask

    task automatic send_pass(input logic [7:0] p, input bit fwd);
        for (int i = 7; i >= 0; i--) send_bit(p[i], fwd);
    endtask

    initial begin
        #(8 * 50000);
        finished = 1;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();

        // clean stream: R2 length, R3 done, R4 payloads, R5 index, R8 pass-through
        send_hdr(8, NF * (FB + 4) + 8, 1'b0);
        send_frame(16'h0000, 0, 0);
        send_frame(16'hFFFF, 0, 0);
        send_frame(16'hA5C3, 0, 0);
        send_frame(16'h1234, 0, 0);
        send_pass(8'b1011_0010, 1'b1);
        send_pass(8'b0110_1111, 1'b1);
        chk(done == 1, "R3", done, 1);
        do_reset();    // R9 after completion

        // R1 header recovery, R2 short length expiring mid-frame
        frm_req = "R1"; done_req = "R2";
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        for (int i = 0; i < 9; i++) send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0);
        send_hdr(12, 30, 1'b0);
        send_frame(16'h8001, 0, 0);
        send_frame(16'h7FFE, 0, 0);
        send_frame(16'h0F0F, 0, 0);
        send_frame(16'hF0F0, 0, 0);
        send_pass(8'b0101_0011, 1'b1);
        do_reset();

        // R6 start-bit error on the second frame
        frm_req = "R4"; done_req = "R3"; err_req = "R6"; extra_req = "R6";
        send_hdr(8, 200, 1'b0);
        send_frame(16'hC3A5, 0, 0);
        send_frame(16'h5555, 1, 0);
        send_frame(16'hAAAA, 0, 0);
        send_pass(8'b0000_1111, 1'b0);
        chk(frame_err == 1, "R6", frame_err, 1);
        do_reset();

        // R6 stop-bit error on the first frame
        send_hdr(9, 200, 1'b0);
        send_frame(16'h3C3C, 0, 1);
        send_frame(16'h0001, 0, 0);
        send_pass(8'b1100_0011, 1'b0);
        do_reset();

        // R7 trailer error
        err_req = "R7"; extra_req = "R7";
        send_hdr(8, 200, 1'b1);
        send_frame(16'h9999, 0, 0);
        send_pass(8'b0011_0101, 1'b0);
        chk(frame_err == 1, "R7", frame_err, 1);
        do_reset();

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule